// File: doc/BRIEF.md
# System-Control Register File with Interrupt Gating

This block holds the privileged control registers of a processor core. Software reaches them through a move-to write port and a move-from read port. Both ports are addressed by a 5-bit register number and a 3-bit select. Each register merges a write through its own pair of masks. One mask names the stored bits that survive the write. The other names the bits taken from the write data. Every remaining bit reads as zero.

The block keeps four live mode flags: user mode, exception level, error level and debug mode. These flags are loaded by writes to the status and debug registers, and they are folded back into those registers when they are read.

A write to the status register that turns interrupts on while an interrupt is already pending raises an interrupt request. A later write that turns interrupts off withdraws that request.

The timer count and compare, the random register, the faulting address and the translation array all sit outside the block. They are reached through side ports:
- read values for those registers;
- write strobes for the timer registers;
- a probe-result update for the index register;
- a load-linked address capture.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, every stored register reads 0. Config0 (register 16, select 0) reads its reset parameter. All four mode flags, `irq_req_o` and `irq_raise_o` are 0.
- R2: A write to register 0 replaces bits 3:0 and keeps the stored bit 31. A probe update with a miss sets bit 31 and keeps the other bits. A probe update with a hit loads the entry index and clears bit 31. A probe update has priority over a software write in the same cycle.
- R3: Writes to the following registers keep only the listed bits:

  | Register | Bits kept from the write |
  |---|---|
  | 2 and 3 | 29:0 |
  | 5 | 24:13 |
  | 6 | 3:0 |
  | 10 | every bit except 11:8 |
  | 19 | mask 0x40FF0FF8 |
  | 28, select 0 | mask 0xFFFFFCF6 |
  | 4 | 23:4 taken from the data; 31:24 keep their stored value; 3:0 read 0 |

- R4: A status write (register 12) stores the data masked with 0xFA78FF01. Bit 4 loads `um_o`, bit 2 loads `erl_o` and bit 1 loads `exl_o`. A status read returns the stored value ORed with those three flags at bits 4, 2 and 1.
- R5: A status write raises an interrupt when all of these hold:
  - bit 0 is set in the data and was clear in the stored value;
  - bits 1 and 2 of the data are clear;
  - `dm_o` is 0;
  - any pending bit (Cause bits 15:8) is set.

  On a raise, `irq_req_o` goes high after the clock edge and `irq_raise_o` pulses for that one cycle.
- R6: A status write that clears bit 0 while the stored bit 0 is 1 drops `irq_req_o` after the edge. In every other case `irq_req_o` holds its value.
- R7: A debug write (register 23) keeps the stored bits under mask 0x8C03FC1F and takes the data bits under mask 0x13300120. Bit 30 of the data loads `dm_o`. A debug read ORs `dm_o` into bit 30.
- R8: `ll_we_i` captures `ll_addr_i`. Register 17 reads that address shifted right by 4. Software writes to register 17 change nothing.
- R9: A non-zero select is legal only on registers 16 and 28. With any other register, a non-zero select drops the write and the read gives data 0 with `rd_valid_o` 0. Select 1 of register 28 is not implemented and reads 0 with `rd_valid_o` 0.
- R10: Register 15 and register 16 select 1 read fixed parameter values and ignore writes. In Config0, only bit 0 is writable. Its stored bits under mask 0xFE17FF80 are kept.
- R11: Register 13 stores only bits 9:8 from writes. Bits 15:10 mirror `hw_irq_i`, and all other bits read 0.
- R12: Reads of registers 1, 8, 9 and 11 return `random_i`, `badvaddr_i`, `count_i` and `compare_i`. A select-0 write to register 9 or 11 drives `count_we_o` or `compare_we_o` high combinationally in that cycle.
- R13: The read port is combinational. Registers 7, 20–22, 25–27 and 29 read 0 with `rd_valid_o` 0. A write becomes visible on `rd_data_o` right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Move-to write strobe |
| wr_num_i | input | 5 | Write register number |
| wr_sel_i | input | 3 | Write select |
| wr_data_i | input | 32 | Write data |
| rd_num_i | input | 5 | Read register number |
| rd_sel_i | input | 3 | Read select |
| rd_data_o | output | 32 | Read data |
| rd_valid_o | output | 1 | Read address names an implemented register |
| hw_irq_i | input | 6 | Hardware interrupt lines (Cause bits 15:10) |
| random_i | input | 32 | External random register value |
| badvaddr_i | input | 32 | External faulting address value |
| count_i | input | 32 | External timer count |
| compare_i | input | 32 | External timer compare |
| count_we_o | output | 1 | Write strobe toward the timer count |
| compare_we_o | output | 1 | Write strobe toward the timer compare |
| probe_upd_i | input | 1 | Translation probe result is valid |
| probe_hit_i | input | 1 | Probe found a matching entry |
| probe_idx_i | input | 4 | Index of the matching entry |
| ll_we_i | input | 1 | Capture a load-linked address |
| ll_addr_i | input | 32 | Load-linked address |
| um_o | output | 1 | User-mode flag |
| erl_o | output | 1 | Error-level flag |
| exl_o | output | 1 | Exception-level flag |
| dm_o | output | 1 | Debug-mode flag |
| irq_req_o | output | 1 | Interrupt request level |
| irq_raise_o | output | 1 | One-cycle pulse when a status write raises an interrupt |

## Verification
The hardest case to reach is a status write that raises an interrupt. It needs the stored enable bit clear, a pending source present, and the debug flag and exception/error bits clear, all in the same cycle as a write that sets the enable bit. The stimulus first writes status to zero and drives a hardware line or a software pending bit. It then writes the enable bit alone. The same sequence is repeated with the debug flag set, with the error bit in the data and with nothing pending, to show that each of these blocks the raise. A second enabling write while already enabled confirms that the pulse needs a 0-to-1 change.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN   = 32;
  localparam int NUM_W  = 5;
  localparam int SEL_W  = 3;
  localparam int NREG   = 1 << NUM_W;
  localparam int IDX_W  = 4;
  localparam int HWI_W  = 6;
  localparam int SWI_W  = 2;
  localparam int PEND_W = HWI_W + SWI_W;

  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_UM  = 4;
  localparam int DBG_DM = 30;
  localparam int SWI_LO = 8;
  localparam int HWI_LO = SWI_LO + SWI_W;
  localparam int LL_SHIFT = 4;

  localparam logic [NUM_W-1:0] N_INDEX  = 5'd0;
  localparam logic [NUM_W-1:0] N_RAND   = 5'd1;
  localparam logic [NUM_W-1:0] N_BADVA  = 5'd8;
  localparam logic [NUM_W-1:0] N_COUNT  = 5'd9;
  localparam logic [NUM_W-1:0] N_CMP    = 5'd11;
  localparam logic [NUM_W-1:0] N_STATUS = 5'd12;
  localparam logic [NUM_W-1:0] N_CAUSE  = 5'd13;
  localparam logic [NUM_W-1:0] N_PRID   = 5'd15;
  localparam logic [NUM_W-1:0] N_CONFIG = 5'd16;
  localparam logic [NUM_W-1:0] N_LLADDR = 5'd17;
  localparam logic [NUM_W-1:0] N_DEBUG  = 5'd23;
  localparam logic [NUM_W-1:0] N_TAG    = 5'd28;

  typedef struct packed {
    logic [XLEN-1:0] keep;
    logic [XLEN-1:0] take;
  } wmask_t;

  function automatic wmask_t wmask_of(input int n);
    wmask_t m;
    m = '{keep: '0, take: '0};
    case (n)
      0:                  m = '{keep: 32'h8000_0000, take: 32'h0000_000F};
      2, 3:               m = '{keep: 32'h0,         take: 32'h3FFF_FFFF};
      4:                  m = '{keep: 32'hFF00_0000, take: 32'h00FF_FFF0};
      5:                  m = '{keep: 32'h0,         take: 32'h01FF_E000};
      6:                  m = '{keep: 32'h0,         take: 32'h0000_000F};
      10:                 m = '{keep: 32'h0,         take: 32'hFFFF_F0FF};
      12:                 m = '{keep: 32'h0,         take: 32'hFA78_FF01};
      13:                 m = '{keep: 32'h0,         take: 32'h0000_0300};
      14, 18, 24, 30, 31: m = '{keep: 32'h0,         take: 32'hFFFF_FFFF};
      16:                 m = '{keep: 32'hFE17_FF80, take: 32'h0000_0001};
      17:                 m = '{keep: 32'hFFFF_FFFF, take: 32'h0};
      19:                 m = '{keep: 32'h0,         take: 32'h40FF_0FF8};
      23:                 m = '{keep: 32'h8C03_FC1F, take: 32'h1330_0120};
      28:                 m = '{keep: 32'h0,         take: 32'hFFFF_FCF6};
      default:            m = '{keep: '0, take: '0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sysctl_slot.sv
module sysctl_slot #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    KEEP = '0,
  parameter logic [W-1:0]    TAKE = '0,
  parameter logic [W-1:0]    RST  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_data_i,
  input  logic         hw_we_i,
  input  logic [W-1:0] hw_data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= RST;
    else if (hw_we_i) q_o <= hw_data_i;
    else if (sw_we_i) q_o <= (q_o & KEEP) | (sw_data_i & TAKE);
  end
endmodule

// File: rtl/sysctl_irq_gate.sv
module sysctl_irq_gate #(
  parameter int PEND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_we_i,
  input  logic              st_ie_i,
  input  logic              st_exl_i,
  input  logic              st_erl_i,
  input  logic              st_um_i,
  input  logic              ie_old_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic              dbg_we_i,
  input  logic              dbg_dm_i,
  output logic              um_o,
  output logic              exl_o,
  output logic              erl_o,
  output logic              dm_o,
  output logic              irq_req_o,
  output logic              irq_raise_o
);
  logic raise, withdraw;

  // flags in the written value are the ones that apply after the write
  assign raise    = st_we_i && st_ie_i && !ie_old_i && !st_exl_i && !st_erl_i
                    && !dm_o && (|pend_i);
  assign withdraw = st_we_i && !st_ie_i && ie_old_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      um_o <= 1'b0; exl_o <= 1'b0; erl_o <= 1'b0; dm_o <= 1'b0;
      irq_req_o <= 1'b0; irq_raise_o <= 1'b0;
    end else begin
      if (st_we_i) begin
        um_o  <= st_um_i;
        exl_o <= st_exl_i;
        erl_o <= st_erl_i;
      end
      if (dbg_we_i) dm_o <= dbg_dm_i;
      irq_raise_o <= raise;
      if (raise)         irq_req_o <= 1'b1;
      else if (withdraw) irq_req_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
  import sysctl_pkg::*;
#(
  parameter logic [XLEN-1:0] PRID_VAL = 32'h0001_8000,
  parameter logic [XLEN-1:0] CFG1_VAL = 32'h1E19_0C8A
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [XLEN-1:0]  slot_i [NREG],
  input  logic [XLEN-1:0]  random_i,
  input  logic [XLEN-1:0]  badvaddr_i,
  input  logic [XLEN-1:0]  count_i,
  input  logic [XLEN-1:0]  compare_i,
  input  logic [HWI_W-1:0] hw_irq_i,
  input  logic             um_i,
  input  logic             erl_i,
  input  logic             exl_i,
  input  logic             dm_i,
  output logic [XLEN-1:0]  data_o,
  output logic             valid_o
);
  logic [XLEN-1:0] st_flags, dbg_flag, hwi_bits;

  always_comb begin
    st_flags = '0;
    st_flags[ST_UM]  = um_i;
    st_flags[ST_ERL] = erl_i;
    st_flags[ST_EXL] = exl_i;
    dbg_flag = '0;
    dbg_flag[DBG_DM] = dm_i;
    hwi_bits = '0;
    hwi_bits[HWI_LO +: HWI_W] = hw_irq_i;
  end

  always_comb begin
    data_o  = '0;
    valid_o = 1'b0;
    if (sel_i == '0) begin
      valid_o = 1'b1;
      case (num_i)
        N_RAND:   data_o = random_i;
        N_BADVA:  data_o = badvaddr_i;
        N_COUNT:  data_o = count_i;
        N_CMP:    data_o = compare_i;
        N_STATUS: data_o = slot_i[num_i] | st_flags;
        N_CAUSE:  data_o = slot_i[num_i] | hwi_bits;
        N_PRID:   data_o = PRID_VAL;
        N_LLADDR: data_o = slot_i[num_i] >> LL_SHIFT;
        N_DEBUG:  data_o = slot_i[num_i] | dbg_flag;
        5'd7, 5'd20, 5'd21, 5'd22, 5'd25, 5'd26, 5'd27, 5'd29: valid_o = 1'b0;
        default:  data_o = slot_i[num_i];
      endcase
    end else if (num_i == N_CONFIG && sel_i == 3'd1) begin
      data_o  = CFG1_VAL;
      valid_o = 1'b1;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] PRID_VAL = 32'h0001_8000,
  parameter logic [31:0] CFG0_RST = 32'h8000_0082,
  parameter logic [31:0] CFG1_VAL = 32'h1E19_0C8A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [4:0]  wr_num_i,
  input  logic [2:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic [4:0]  rd_num_i,
  input  logic [2:0]  rd_sel_i,
  output logic [31:0] rd_data_o,
  output logic        rd_valid_o,
  input  logic [5:0]  hw_irq_i,
  input  logic [31:0] random_i,
  input  logic [31:0] badvaddr_i,
  input  logic [31:0] count_i,
  input  logic [31:0] compare_i,
  output logic        count_we_o,
  output logic        compare_we_o,
  input  logic        probe_upd_i,
  input  logic        probe_hit_i,
  input  logic [3:0]  probe_idx_i,
  input  logic        ll_we_i,
  input  logic [31:0] ll_addr_i,
  output logic        um_o,
  output logic        erl_o,
  output logic        exl_o,
  output logic        dm_o,
  output logic        irq_req_o,
  output logic        irq_raise_o
);
  logic [XLEN-1:0] slot_q [NREG];
  logic            wr_sel0;
  logic [XLEN-1:0] idx_hw_data;
  logic [PEND_W-1:0] pend;

  assign wr_sel0 = wr_en_i && (wr_sel_i == '0);
  assign count_we_o   = wr_sel0 && (wr_num_i == N_COUNT);
  assign compare_we_o = wr_sel0 && (wr_num_i == N_CMP);

  assign idx_hw_data = probe_hit_i ? {{(XLEN-IDX_W){1'b0}}, probe_idx_i}
                                   : (slot_q[N_INDEX] | {1'b1, {(XLEN-1){1'b0}}});

  for (genvar n = 0; n < NREG; n++) begin : g_slot
    localparam wmask_t M = wmask_of(n);
    localparam logic [XLEN-1:0] RST_N = (n == int'(N_CONFIG)) ? CFG0_RST : '0;
    logic            hw_we;
    logic [XLEN-1:0] hw_data;
    if (n == int'(N_INDEX)) begin : g_probe
      assign hw_we   = probe_upd_i;
      assign hw_data = idx_hw_data;
    end else if (n == int'(N_LLADDR)) begin : g_ll
      assign hw_we   = ll_we_i;
      assign hw_data = ll_addr_i;
    end else begin : g_sw_only
      assign hw_we   = 1'b0;
      assign hw_data = '0;
    end
    sysctl_slot #(.W(XLEN), .KEEP(M.keep), .TAKE(M.take), .RST(RST_N)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sw_we_i   (wr_sel0 && (wr_num_i == n[NUM_W-1:0])),
      .sw_data_i (wr_data_i),
      .hw_we_i   (hw_we),
      .hw_data_i (hw_data),
      .q_o       (slot_q[n])
    );
  end

  assign pend = {hw_irq_i, slot_q[N_CAUSE][SWI_LO +: SWI_W]};

  sysctl_irq_gate #(.PEND_W(PEND_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_we_i     (wr_sel0 && (wr_num_i == N_STATUS)),
    .st_ie_i     (wr_data_i[ST_IE]),
    .st_exl_i    (wr_data_i[ST_EXL]),
    .st_erl_i    (wr_data_i[ST_ERL]),
    .st_um_i     (wr_data_i[ST_UM]),
    .ie_old_i    (slot_q[N_STATUS][ST_IE]),
    .pend_i      (pend),
    .dbg_we_i    (wr_sel0 && (wr_num_i == N_DEBUG)),
    .dbg_dm_i    (wr_data_i[DBG_DM]),
    .um_o        (um_o),
    .exl_o       (exl_o),
    .erl_o       (erl_o),
    .dm_o        (dm_o),
    .irq_req_o   (irq_req_o),
    .irq_raise_o (irq_raise_o)
  );

  sysctl_rd_mux #(.PRID_VAL(PRID_VAL), .CFG1_VAL(CFG1_VAL)) u_rd (
    .num_i      (rd_num_i),
    .sel_i      (rd_sel_i),
    .slot_i     (slot_q),
    .random_i   (random_i),
    .badvaddr_i (badvaddr_i),
    .count_i    (count_i),
    .compare_i  (compare_i),
    .hw_irq_i   (hw_irq_i),
    .um_i       (um_o),
    .erl_i      (erl_o),
    .exl_i      (exl_o),
    .dm_i       (dm_o),
    .data_o     (rd_data_o),
    .valid_o    (rd_valid_o)
  );
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [4:0]  wr_num_i,
  input logic [2:0]  wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic [4:0]  rd_num_i,
  input logic [2:0]  rd_sel_i,
  input logic [31:0] rd_data_o,
  input logic        rd_valid_o,
  input logic        count_we_o,
  input logic        compare_we_o,
  input logic        um_o,
  input logic        erl_o,
  input logic        exl_o,
  input logic        dm_o,
  input logic        irq_req_o,
  input logic        irq_raise_o
);
  logic st_wr, dbg_wr;
  assign st_wr  = wr_en_i && wr_sel_i == 3'd0 && wr_num_i == 5'd12;
  assign dbg_wr = wr_en_i && wr_sel_i == 3'd0 && wr_num_i == 5'd23;

  p_flags_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr |=> (um_o == $past(wr_data_i[4]) && erl_o == $past(wr_data_i[2])
               && exl_o == $past(wr_data_i[1])));

  p_flags_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_wr |=> ($stable(um_o) && $stable(erl_o) && $stable(exl_o)));

  p_raise_has_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raise_o |-> irq_req_o);

  p_raise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raise_o |=> !irq_raise_o);

  p_rise_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> $past(st_wr && wr_data_i[0] && !wr_data_i[1]
                               && !wr_data_i[2] && !dm_o));

  p_fall_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_req_o) |-> $past(st_wr && !wr_data_i[0]));

  p_dm_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wr |=> dm_o == $past(wr_data_i[30]));

  p_dm_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_wr |=> $stable(dm_o));

  p_badsel_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i != 3'd0 && rd_num_i != 5'd16) |-> (!rd_valid_o && rd_data_o == 32'h0));

  p_badsel_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_we_o || compare_we_o) |-> (wr_en_i && wr_sel_i == 3'd0));

  p_strobe_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(count_we_o && compare_we_o));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_num_i     (wr_num_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .rd_num_i     (rd_num_i),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .rd_valid_o   (rd_valid_o),
  .count_we_o   (count_we_o),
  .compare_we_o (compare_we_o),
  .um_o         (um_o),
  .erl_o        (erl_o),
  .exl_o        (exl_o),
  .dm_o         (dm_o),
  .irq_req_o    (irq_req_o),
  .irq_raise_o  (irq_raise_o)
);

// File: tb/sysctl_regfile_tb_top.sv
module sysctl_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PRID = 32'h0001_8000;
  localparam logic [31:0] CFG0 = 32'h8000_0082;
  localparam logic [31:0] CFG1 = 32'h1E19_0C8A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0; logic [4:0] wr_num = 0; logic [2:0] wr_sel = 0; logic [31:0] wr_data = 0;
  logic [4:0] rd_num = 0; logic [2:0] rd_sel = 0;
  logic [31:0] rd_data; logic rd_valid;
  logic [5:0] hw_irq = 0;
  logic [31:0] random_v = 0, badva_v = 0, count_v = 0, cmp_v = 0;
  logic count_we, cmp_we;
  logic probe_upd = 0, probe_hit = 0; logic [3:0] probe_idx = 0;
  logic ll_we = 0; logic [31:0] ll_addr = 0;
  logic um, erl, exl, dm, irq_req, irq_raise;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile #(.PRID_VAL(PRID), .CFG0_RST(CFG0), .CFG1_VAL(CFG1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_num_i(wr_num), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_num_i(rd_num), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .hw_irq_i(hw_irq), .random_i(random_v), .badvaddr_i(badva_v), .count_i(count_v),
    .compare_i(cmp_v), .count_we_o(count_we), .compare_we_o(cmp_we),
    .probe_upd_i(probe_upd), .probe_hit_i(probe_hit), .probe_idx_i(probe_idx),
    .ll_we_i(ll_we), .ll_addr_i(ll_addr),
    .um_o(um), .erl_o(erl), .exl_o(exl), .dm_o(dm),
    .irq_req_o(irq_req), .irq_raise_o(irq_raise)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_num = n; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] d, output logic v);
    rd_num = n; rd_sel = s; #1; d = rd_data; v = rd_valid;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] n, input logic [2:0] s,
                        input logic [31:0] exp, input logic expv);
    logic [31:0] d; logic v;
    rd(n, s, d, v);
    chk(req, $sformatf("read %0d/%0d data", n, s), d, exp);
    chk(req, $sformatf("read %0d/%0d valid", n, s), {31'b0, v}, {31'b0, expv});
  endtask

  task automatic t_reset;
    rd_chk("R1", 5'd12, 3'd0, 32'h0, 1'b1);
    rd_chk("R1", 5'd16, 3'd0, CFG0, 1'b1);
    rd_chk("R1", 5'd0, 3'd0, 32'h0, 1'b1);
    chk("R1", "flags", {28'b0, um, erl, exl, dm}, 32'h0);
    chk("R1", "irq", {30'b0, irq_req, irq_raise}, 32'h0);
  endtask

  task automatic t_index;
    wr(5'd0, 3'd0, 32'hFFFF_FFFF);
    rd_chk("R2", 5'd0, 3'd0, 32'h0000_000F, 1'b1);
    @(negedge clk); probe_upd = 1; probe_hit = 0;
    @(negedge clk); probe_upd = 0;
    rd_chk("R2", 5'd0, 3'd0, 32'h8000_000F, 1'b1);
    wr(5'd0, 3'd0, 32'h0000_0005);
    rd_chk("R2", 5'd0, 3'd0, 32'h8000_0005, 1'b1);
    @(negedge clk); probe_upd = 1; probe_hit = 1; probe_idx = 4'd9;
    wr_en = 1; wr_num = 5'd0; wr_sel = 3'd0; wr_data = 32'h3;
    @(negedge clk); probe_upd = 0; probe_hit = 0; wr_en = 0;
    rd_chk("R2", 5'd0, 3'd0, 32'h0000_0009, 1'b1);
  endtask

  task automatic t_masks;
    wr(5'd2, 3'd0, 32'hFFFF_FFFF);  rd_chk("R3", 5'd2, 3'd0, 32'h3FFF_FFFF, 1'b1);
    wr(5'd3, 3'd0, 32'hFFFF_FFFF);  rd_chk("R3", 5'd3, 3'd0, 32'h3FFF_FFFF, 1'b1);
    wr(5'd5, 3'd0, 32'hFFFF_FFFF);  rd_chk("R3", 5'd5, 3'd0, 32'h01FF_E000, 1'b1);
    wr(5'd6, 3'd0, 32'hFFFF_FFFF);  rd_chk("R3", 5'd6, 3'd0, 32'h0000_000F, 1'b1);
    wr(5'd10, 3'd0, 32'hFFFF_FFFF); rd_chk("R3", 5'd10, 3'd0, 32'hFFFF_F0FF, 1'b1);
    wr(5'd4, 3'd0, 32'hFFFF_FFFF);  rd_chk("R3", 5'd4, 3'd0, 32'h00FF_FFF0, 1'b1);
    wr(5'd19, 3'd0, 32'hFFFF_FFFF); rd_chk("R3", 5'd19, 3'd0, 32'h40FF_0FF8, 1'b1);
    wr(5'd28, 3'd0, 32'hFFFF_FFFF); rd_chk("R3", 5'd28, 3'd0, 32'hFFFF_FCF6, 1'b1);
    wr(5'd14, 3'd0, 32'h1234_ABCD); rd_chk("R13", 5'd14, 3'd0, 32'h1234_ABCD, 1'b1);
    rd_chk("R13", 5'd7, 3'd0, 32'h0, 1'b0);
    rd_chk("R13", 5'd29, 3'd0, 32'h0, 1'b0);
  endtask

  task automatic t_status;
    wr(5'd12, 3'd0, 32'hFFFF_FFFF);
    rd_chk("R4", 5'd12, 3'd0, 32'hFA78_FF17, 1'b1);
    chk("R4", "um/erl/exl", {29'b0, um, erl, exl}, 32'h7);
    chk("R5", "no raise with exl/erl", {31'b0, irq_raise}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0000);
    rd_chk("R4", 5'd12, 3'd0, 32'h0, 1'b1);
    chk("R4", "flags cleared", {29'b0, um, erl, exl}, 32'h0);
  endtask

  task automatic t_irq;
    wr(5'd12, 3'd0, 32'h0);
    hw_irq = 6'b000100;
    wr(5'd12, 3'd0, 32'h1);
    chk("R5", "raise pulse", {31'b0, irq_raise}, 32'h1);
    chk("R5", "req set", {31'b0, irq_req}, 32'h1);
    @(negedge clk);
    chk("R5", "pulse one cycle", {31'b0, irq_raise}, 32'h0);
    chk("R5", "req held", {31'b0, irq_req}, 32'h1);
    wr(5'd12, 3'd0, 32'h1);
    chk("R5", "no raise when already enabled", {31'b0, irq_raise}, 32'h0);
    chk("R6", "req held on re-enable", {31'b0, irq_req}, 32'h1);
    wr(5'd12, 3'd0, 32'h0);
    chk("R6", "req withdrawn", {31'b0, irq_req}, 32'h0);
    hw_irq = 6'b0;
    wr(5'd12, 3'd0, 32'h1);
    chk("R5", "no pending no raise", {31'b0, irq_req}, 32'h0);
    wr(5'd12, 3'd0, 32'h0);
    hw_irq = 6'b000001;
    wr(5'd12, 3'd0, 32'h5);
    chk("R5", "erl blocks raise", {31'b0, irq_req}, 32'h0);
    wr(5'd12, 3'd0, 32'h0);
    hw_irq = 6'b0;
    wr(5'd13, 3'd0, 32'hFFFF_FFFF);
    hw_irq = 6'b100001;
    rd_chk("R11", 5'd13, 3'd0, 32'h0000_8700, 1'b1);
    hw_irq = 6'b0;
    wr(5'd12, 3'd0, 32'h1);
    chk("R5", "sw pending raises", {31'b0, irq_req}, 32'h1);
    wr(5'd12, 3'd0, 32'h0);
    wr(5'd23, 3'd0, 32'h4000_0000);
    wr(5'd12, 3'd0, 32'h1);
    chk("R5", "debug mode blocks raise", {31'b0, irq_req}, 32'h0);
    wr(5'd12, 3'd0, 32'h0);
    wr(5'd23, 3'd0, 32'h0);
    wr(5'd13, 3'd0, 32'h0);
  endtask

  task automatic t_debug;
    wr(5'd23, 3'd0, 32'hFFFF_FFFF);
    chk("R7", "dm set", {31'b0, dm}, 32'h1);
    rd_chk("R7", 5'd23, 3'd0, 32'h5330_0120, 1'b1);
    wr(5'd23, 3'd0, 32'h0);
    chk("R7", "dm clear", {31'b0, dm}, 32'h0);
    rd_chk("R7", 5'd23, 3'd0, 32'h0, 1'b1);
  endtask

  task automatic t_ll;
    @(negedge clk); ll_we = 1; ll_addr = 32'h1234_5678;
    @(negedge clk); ll_we = 0;
    rd_chk("R8", 5'd17, 3'd0, 32'h0123_4567, 1'b1);
    wr(5'd17, 3'd0, 32'hFFFF_FFFF);
    rd_chk("R8", 5'd17, 3'd0, 32'h0123_4567, 1'b1);
  endtask

  task automatic t_select;
    wr(5'd12, 3'd1, 32'h0000_0013);
    rd_chk("R9", 5'd12, 3'd0, 32'h0, 1'b1);
    chk("R9", "dropped status write flags", {28'b0, um, erl, exl, irq_req}, 32'h0);
    rd_chk("R9", 5'd12, 3'd1, 32'h0, 1'b0);
    rd_chk("R9", 5'd28, 3'd1, 32'h0, 1'b0);
    wr(5'd28, 3'd1, 32'h0);
    rd_chk("R9", 5'd28, 3'd0, 32'hFFFF_FCF6, 1'b1);
    rd_chk("R10", 5'd16, 3'd1, CFG1, 1'b1);
    wr(5'd16, 3'd1, 32'hFFFF_FFFF);
    rd_chk("R10", 5'd16, 3'd1, CFG1, 1'b1);
    rd_chk("R10", 5'd16, 3'd0, CFG0, 1'b1);
  endtask

  task automatic t_const;
    rd_chk("R10", 5'd15, 3'd0, PRID, 1'b1);
    wr(5'd15, 3'd0, 32'hFFFF_FFFF);
    rd_chk("R10", 5'd15, 3'd0, PRID, 1'b1);
    wr(5'd16, 3'd0, 32'hFFFF_FFFF);
    rd_chk("R10", 5'd16, 3'd0, 32'h8000_0081, 1'b1);
    wr(5'd16, 3'd0, 32'h0);
    rd_chk("R10", 5'd16, 3'd0, 32'h8000_0080, 1'b1);
  endtask

  task automatic t_ext;
    random_v = 32'h5; badva_v = 32'hDEAD_0000; count_v = 32'h1111; cmp_v = 32'h2222;
    rd_chk("R12", 5'd1, 3'd0, 32'h5, 1'b1);
    rd_chk("R12", 5'd8, 3'd0, 32'hDEAD_0000, 1'b1);
    rd_chk("R12", 5'd9, 3'd0, 32'h1111, 1'b1);
    rd_chk("R12", 5'd11, 3'd0, 32'h2222, 1'b1);
    @(negedge clk); wr_en = 1; wr_num = 5'd9; wr_sel = 3'd0; #1;
    chk("R12", "count strobe", {30'b0, count_we, cmp_we}, 32'h2);
    wr_num = 5'd11; #1;
    chk("R12", "compare strobe", {30'b0, count_we, cmp_we}, 32'h1);
    wr_num = 5'd9; wr_sel = 3'd1; #1;
    chk("R9", "no strobe on bad select", {30'b0, count_we, cmp_we}, 32'h0);
    @(negedge clk); wr_en = 0; wr_sel = 3'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_index;
    t_masks;
    t_status;
    t_irq;
    t_debug;
    t_ll;
    t_select;
    t_const;
    t_ext;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule